// File: doc/BRIEF.md
# DMA Coherency Invalidation Tracker

This block keeps a write-through data cache coherent while an external DMA master writes memory. It arbitrates the shared bus by answering a bus request with a grant. The grant is given only after any processor bus transaction in progress has finished, and it is withdrawn as soon as the request goes away.

While the grant is held and the master flags its operations as coherent, the block listens on the multiplexed address/data bus. When the master strobes the latch signal on a write, the block takes the word address of the write target. That address is the high address bits together with the 2-bit low word address. From then on, each acknowledged write transfer moves an internal word counter forward by one. A cache line is one 32-bit word, so a burst write walks through consecutive lines.

Whenever the DMA controller raises its invalidate request, the block sends the cache a one-cycle invalidate pulse that carries the current word address.

Top module: `dmaInvTracker`

## Requirements
- R1: After reset, `busGrant` and `invValid` are 0. `invWordAddr` and the internal word counter are 0.
- R2: `busGrant` rises at the first clock edge that samples `busReq`=1 with `cpuBusy`=0. While not yet granted, any edge that samples `cpuBusy`=1 leaves `busGrant` at 0.
- R3: While granted, `busGrant` falls at the first clock edge that samples `busReq`=0.
- R4: With `busGrant`=1 and `coherentReq`=1, an edge that samples `latchStrobe`=1 and `dmaWrite`=1 loads the word counter with {`busAddr`, `lowWord`}, with `lowWord` as the two least significant bits.
- R5: With `busGrant`=1 and `coherentReq`=1, each edge that samples `xferAck`=1 and `dmaWrite`=1 (and no `latchStrobe`) adds one word to the counter.
- R6: An edge that samples `invReq`=1 while `busGrant`=1 and `coherentReq`=1 makes `invValid` high for the following cycle. In that cycle `invWordAddr` carries the counter value from before that edge, so an acknowledge or capture in the same cycle does not affect it. `invValid` is 0 in every other cycle.
- R7: Without `coherentReq`=1 together with `busGrant`=1, the latch strobe, acknowledges and invalidate requests have no effect: no pulse is produced and the counter keeps its value.
- R8: With `dmaWrite`=0 (a read transfer), neither the latch strobe nor the acknowledge changes the counter.
- R9: When the latch strobe and an acknowledge fall in the same cycle, the capture wins and the counter takes the new address without the increment.
- R10: The counter wraps modulo 2^(HI_W+2), so the word after the all-ones address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | External master asks for the bus |
| cpuBusy | input | 1 | Processor bus transaction in progress |
| busGrant | output | 1 | Bus released to the external master |
| coherentReq | input | 1 | Granted DMA needs cache invalidation |
| dmaWrite | input | 1 | Transfer direction, 1 = write |
| latchStrobe | input | 1 | Address latch strobe from the master |
| busAddr | input | HI_W | High word-address bits sampled from the bus |
| lowWord | input | 2 | Low word address bits |
| xferAck | input | 1 | One write transfer completed |
| invReq | input | 1 | Request to invalidate the current line |
| invValid | output | 1 | Invalidate pulse to the data cache |
| invWordAddr | output | HI_W+2 | Word address of the line to invalidate |

## Verification
An invalidate request and a transfer acknowledge can land in the same cycle. This is the normal way to walk a burst, with one line invalidated per beat. The bench holds both strobes together on every beat of every burst. Each pulse must carry the address from before that beat's increment, and a lone request after the burst must show the base address plus the beat count. The same check is run for every low-word offset, for burst lengths from zero to five, and for several high addresses, one of them at the top of the range. A capture that coincides with an acknowledge is also provoked, and it is judged by the address that the next invalidate reports.

// File: rtl/dmaInvPkg.sv
package dmaInvPkg;
  typedef struct packed {
    logic capture;
    logic step;
    logic issue;
  } invCtlT;
endpackage

// File: rtl/dmaInvCtrl.sv
module dmaInvCtrl
  import dmaInvPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   busReq,
  input  logic   cpuBusy,
  input  logic   coherentReq,
  input  logic   dmaWrite,
  input  logic   latchStrobe,
  input  logic   xferAck,
  input  logic   invReq,
  output logic   busGrant,
  output invCtlT ctl
);
  logic grantQ;
  logic snoopOn;

  // grant waits for the processor to leave the bus, drops with the request
  always_ff @(posedge clk) begin
    if (!rstN) grantQ <= 1'b0;
    else       grantQ <= busReq && (grantQ || !cpuBusy);
  end

  assign busGrant = grantQ;
  assign snoopOn  = grantQ && coherentReq;

  always_comb begin
    ctl.capture = snoopOn && dmaWrite && latchStrobe;
    // a capture in the same cycle takes priority over the increment
    ctl.step    = snoopOn && dmaWrite && xferAck && !latchStrobe;
    ctl.issue   = snoopOn && invReq;
  end
endmodule

// File: rtl/dmaInvPath.sv
module dmaInvPath
  import dmaInvPkg::*;
#(
  parameter int HI_W = 28,
  localparam int WA_W = HI_W + 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  invCtlT          ctl,
  input  logic [HI_W-1:0] busAddr,
  input  logic [1:0]      lowWord,
  output logic [WA_W-1:0] wordCnt,
  output logic            invValid,
  output logic [WA_W-1:0] invWordAddr
);
  logic [WA_W-1:0] cntQ;
  logic [WA_W-1:0] cntNext;

  always_comb begin
    cntNext = cntQ;
    if (ctl.capture)   cntNext = {busAddr, lowWord};
    else if (ctl.step) cntNext = cntQ + WA_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ        <= '0;
      invValid    <= 1'b0;
      invWordAddr <= '0;
    end else begin
      cntQ     <= cntNext;
      invValid <= ctl.issue;
      if (ctl.issue) invWordAddr <= cntQ;
    end
  end

  assign wordCnt = cntQ;
endmodule

// File: rtl/dmaInvTracker.sv
module dmaInvTracker
  import dmaInvPkg::*;
#(
  parameter int HI_W = 28,
  localparam int WA_W = HI_W + 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busReq,
  input  logic            cpuBusy,
  output logic            busGrant,
  input  logic            coherentReq,
  input  logic            dmaWrite,
  input  logic            latchStrobe,
  input  logic [HI_W-1:0] busAddr,
  input  logic [1:0]      lowWord,
  input  logic            xferAck,
  input  logic            invReq,
  output logic            invValid,
  output logic [WA_W-1:0] invWordAddr
);
  invCtlT          ctl;
  logic [WA_W-1:0] wordCnt;

  dmaInvCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .busReq(busReq), .cpuBusy(cpuBusy),
    .coherentReq(coherentReq), .dmaWrite(dmaWrite),
    .latchStrobe(latchStrobe), .xferAck(xferAck), .invReq(invReq),
    .busGrant(busGrant), .ctl(ctl)
  );

  dmaInvPath #(.HI_W(HI_W)) path_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busAddr(busAddr),
    .lowWord(lowWord), .wordCnt(wordCnt), .invValid(invValid),
    .invWordAddr(invWordAddr)
  );
endmodule

// File: rtl/dmaInvChecker.sv
module dmaInvChecker #(
  parameter int WA_W = 30
) (
  input logic            clk,
  input logic            rstN,
  input logic            busReq,
  input logic            cpuBusy,
  input logic            busGrant,
  input logic            coherentReq,
  input logic            dmaWrite,
  input logic            latchStrobe,
  input logic            xferAck,
  input logic            invReq,
  input logic            invValid,
  input logic [WA_W-1:0] invWordAddr,
  input logic [WA_W-1:0] wordCnt
);
  AST_GRANT_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (!busGrant && cpuBusy) |=> !busGrant); // R2

  AST_GRANT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (busGrant && !busReq) |=> !busGrant); // R3

  AST_STEP_ONE_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (busGrant && coherentReq && dmaWrite && xferAck && !latchStrobe)
      |=> wordCnt == $past(wordCnt) + WA_W'(1)); // R5

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (busGrant && coherentReq && invReq) |=> (invValid && invWordAddr == $past(wordCnt))); // R6

  AST_IGNORED_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !(busGrant && coherentReq) |=> !invValid); // R7

  AST_IGNORED_NO_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    !(busGrant && coherentReq) |=> $stable(wordCnt)); // R7

  AST_READ_NO_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    !dmaWrite |=> $stable(wordCnt)); // R8
endmodule

bind dmaInvTracker dmaInvChecker #(.WA_W(WA_W)) chk_i (
  .clk(clk), .rstN(rstN), .busReq(busReq), .cpuBusy(cpuBusy),
  .busGrant(busGrant), .coherentReq(coherentReq), .dmaWrite(dmaWrite),
  .latchStrobe(latchStrobe), .xferAck(xferAck), .invReq(invReq),
  .invValid(invValid), .invWordAddr(invWordAddr), .wordCnt(wordCnt)
);

// File: tb/dmaInvTracker_tb.sv
`timescale 1ns/1ps
module dmaInvTracker_tb_top;
  localparam int HI_W = 28;
  localparam int WA_W = HI_W + 2;

  logic clk = 1'b0;
  logic rstN, busReq, cpuBusy, busGrant, coherentReq, dmaWrite;
  logic latchStrobe, xferAck, invReq, invValid;
  logic [HI_W-1:0] busAddr;
  logic [1:0]      lowWord;
  logic [WA_W-1:0] invWordAddr;
  int total = 0;
  int bad = 0;
  logic [WA_W-1:0] held;

  always #2 clk = ~clk;

  dmaInvTracker #(.HI_W(HI_W)) dut_i (
    .clk(clk), .rstN(rstN), .busReq(busReq), .cpuBusy(cpuBusy),
    .busGrant(busGrant), .coherentReq(coherentReq), .dmaWrite(dmaWrite),
    .latchStrobe(latchStrobe), .busAddr(busAddr), .lowWord(lowWord),
    .xferAck(xferAck), .invReq(invReq), .invValid(invValid),
    .invWordAddr(invWordAddr)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [WA_W-1:0] act, input logic [WA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    latchStrobe = 0; xferAck = 0; invReq = 0; dmaWrite = 1;
  endtask

  // one lone invalidate request, then check the pulse and its clearing
  task automatic probe(input string tag, input logic [WA_W-1:0] exp);
    invReq = 1; cyc(); invReq = 0;
    chk({tag, " pulse"}, WA_W'(invValid), 1);
    chk({tag, " addr"}, invWordAddr, exp);
    cyc();
    chk("R6 one-cycle pulse", WA_W'(invValid), 0);
  endtask

  task automatic burst(input logic [HI_W-1:0] hi, input logic [1:0] lw, input int n);
    logic [WA_W-1:0] base;
    base = {hi, lw};
    dmaWrite = 1; latchStrobe = 1; busAddr = hi; lowWord = lw;
    cyc(); latchStrobe = 0;
    for (int i = 0; i < n; i++) begin
      invReq = 1; xferAck = 1; cyc();
      chk("R6 beat pulse", WA_W'(invValid), 1);
      chk("R4 R6 beat addr", invWordAddr, base + WA_W'(i));
    end
    invReq = 0; xferAck = 0;
    probe("R5 R10 after burst", base + WA_W'(n));
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [HI_W-1:0] his [4];
    his[0] = '0; his[1] = 28'd5; his[2] = 28'hABCDEF1; his[3] = '1;
    rstN = 0; busReq = 0; cpuBusy = 0; coherentReq = 0;
    busAddr = '0; lowWord = 0; quiet();
    cyc(); cyc(); cyc();
    chk("R1 grant", WA_W'(busGrant), 0);
    chk("R1 invValid", WA_W'(invValid), 0);
    chk("R1 addr", invWordAddr, 0);
    rstN = 1; cyc();

    busReq = 1; cpuBusy = 1; cyc();
    chk("R2 wait busy", WA_W'(busGrant), 0);
    cyc();
    chk("R2 still busy", WA_W'(busGrant), 0);
    cpuBusy = 0; cyc();
    chk("R2 grant", WA_W'(busGrant), 1);
    cpuBusy = 1; cyc();
    chk("R2 grant held", WA_W'(busGrant), 1);
    cpuBusy = 0;

    // counter still at reset value
    coherentReq = 1;
    probe("R1 counter", 0);

    for (int h = 0; h < 4; h++)
      for (int lw = 0; lw < 4; lw++)
        for (int n = 0; n <= 5; n++)
          burst(his[h], 2'(lw), n);

    // R10 explicit wrap
    burst('1, 2'd3, 2);

    // R8 read transfers leave the counter alone
    burst(28'h1234567, 2'd1, 0);
    held = {28'h1234567, 2'd1};
    dmaWrite = 0; latchStrobe = 1; busAddr = 28'h7654321; lowWord = 2'd2; cyc();
    latchStrobe = 0; xferAck = 1; cyc(); xferAck = 0;
    probe("R8 read ignored", held);
    dmaWrite = 1;

    // R9 capture beats acknowledge
    latchStrobe = 1; xferAck = 1; busAddr = 28'h0F0F0F0; lowWord = 2'd2; cyc();
    quiet();
    held = {28'h0F0F0F0, 2'd2};
    probe("R9 capture wins", held);

    // R7 without coherent request
    coherentReq = 0;
    latchStrobe = 1; busAddr = 28'h5555555; lowWord = 2'd0; cyc(); latchStrobe = 0;
    chk("R7 no pulse strobe", WA_W'(invValid), 0);
    xferAck = 1; invReq = 1; cyc(); xferAck = 0; invReq = 0;
    chk("R7 request ignored", WA_W'(invValid), 0);
    cyc();
    chk("R7 still quiet", WA_W'(invValid), 0);
    coherentReq = 1;
    probe("R7 counter kept", held);

    // R3 release, then requests without grant are ignored
    busReq = 0; cyc();
    chk("R3 grant drops", WA_W'(busGrant), 0);
    invReq = 1; xferAck = 1; cyc(); quiet();
    chk("R7 no grant no pulse", WA_W'(invValid), 0);
    busReq = 1; cyc();
    chk("R2 regrant", WA_W'(busGrant), 1);
    probe("R7 counter kept no grant", held);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule